// File: doc/BRIEF.md
# SMBus Host Register Block

This block is the software-visible register set of an SMBus host controller. A processor reaches it over a simple byte-wide bus with a select, a write enable and a 3-bit offset. It holds the transaction set-up for a protocol sequencer: the command byte, the target address, two data bytes, a block data byte and the protocol code. It turns a write of the start bit into a one-cycle start pulse. It tracks host busy, and it latches the events the sequencer reports back in status flags that are cleared by writing one.

The status register also carries an ownership semaphore for software that shares the controller. A status read that finds the semaphore free returns it as free and claims it in the same access. Every later read then sees it taken until the owner writes one to release it. A kill request can always get through, even while the host is busy. It aborts the running transaction and is recorded as a failure. One interrupt line combines the enabled completion, device-error and failure flags.

Top module: `smb_host_regs`

## Requirements
- R1: After synchronous reset every status flag is 0 (status reads 0x00), every stored register reads 0x00, the protocol code is 0 and the interrupt line is low; a reset while busy also drops busy.
- R2: Status bit 6 is the semaphore. A status read that returns it as 0 sets it at that access, later status reads return 1, and writing 1 to bit 6 frees it.
- R3: Status bits 1, 2, 4, 6 and 7 clear on writing 1 and keep their value on writing 0. Writing 0xBF clears all of them except bit 6, and writing 0xFF clears all of them. Bit 0 (busy) cannot be written, and bits 3 and 5 read 0.
- R4: Writing control (offset 2) with bit 6 set while idle raises seq_start for exactly the cycle after the write. seq_proto takes bits 4:2 of that write. Bit 6 reads back as 0.
- R5: Busy (status bit 0) is set the cycle after seq_start. It stays set until seq_done sets completion (bit 1) or seq_dev_err sets device error (bit 2), either of which clears busy.
- R6: Writing control with bit 1 set gives a one-cycle seq_kill, whether or not the host is busy. If busy, the next cycle clears busy and sets the failed flag (bit 4). If idle, no flag changes.
- R7: irq is high exactly when control bit 0 (interrupt enable) is 1 and at least one of status bits 1, 2 or 4 is set.
- R8: While busy, bus writes to the command, address, data 0, data 1 and block data registers are ignored, and so are the enable, protocol and start fields of control.
- R9: A seq_byte_done pulse sets status bit 7 (block byte done).
- R10: A seq_rx_valid cycle loads seq_rx_byte into data 0 (seq_rx_sel 0), data 1 (1) or block data (2).
- R11: Idle writes to command (3), address (4), data 0 (5), data 1 (6) and block data (7) read back and appear on the seq_* outputs. Control reads back enable in bit 0 and protocol in bits 4:2, with reserved bit 7 dropped. Offset 1 reads 0.
- R12: When a hardware event and a write-one-to-clear hit the same status flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| seq_start | output | 1 | One-cycle transaction start |
| seq_kill | output | 1 | One-cycle abort request |
| seq_proto | output | 3 | Protocol code |
| seq_cmd | output | 8 | Command byte |
| seq_saddr | output | 8 | Target address byte |
| seq_data0 | output | 8 | Data 0 |
| seq_data1 | output | 8 | Data 1 |
| seq_blk | output | 8 | Block data byte |
| seq_done | input | 1 | Transaction completed |
| seq_dev_err | input | 1 | Device did not acknowledge |
| seq_byte_done | input | 1 | One block byte moved |
| seq_rx_valid | input | 1 | Received byte valid |
| seq_rx_sel | input | 2 | Received byte target: 0 data 0, 1 data 1, 2 block |
| seq_rx_byte | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
Register storage is tried with a vector walk: distinct byte patterns at each offset, a write to the unused offset and a write of a reserved control bit. This separates offset decode errors and field masking errors from storage errors. The status register is tried with read sequences, so a free semaphore and a taken one give different results, and with write masks 0x40, 0xBF, 0xFF and single bits, which show whether clearing is selective. Transactions are ended in three ways (completion, device error, kill), so a wrong flag or a busy bit left set shows up. Kill is also sent while idle to show that no failure is recorded then. Writes during busy and a clear that lands in the same cycle as a set check the blocking and priority rules.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
    localparam int DW      = 8;
    localparam int PROTO_W = 3;
    localparam int NDATA   = 5;   // command, address, data0, data1, block

    // Register offsets (software-visible map)
    localparam int OFS_STAT = 0;
    localparam int OFS_CTRL = 2;
    localparam int OFS_CMD  = 3;
    localparam int OFS_SADR = 4;
    localparam int OFS_D0   = 5;
    localparam int OFS_D1   = 6;
    localparam int OFS_BLK  = 7;

    // Status bit positions
    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_DEV   = 2;
    localparam int ST_FAIL  = 4;
    localparam int ST_OWN   = 6;
    localparam int ST_BYTE  = 7;

    // Control bit positions
    localparam int CT_IE    = 0;
    localparam int CT_KILL  = 1;
    localparam int CT_PR_LO = 2;
    localparam int CT_GO    = 6;

    typedef struct packed {
        logic byte_done;
        logic owned;
        logic failed;
        logic dev_err;
        logic done;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic byte_done;
        logic owned;
        logic failed;
        logic dev_err;
        logic done;
    } flag_clr_t;

    typedef enum logic [1:0] {
        RX_DATA0 = 2'd0,
        RX_DATA1 = 2'd1,
        RX_BLOCK = 2'd2
    } rx_tgt_e;

    function automatic logic [DW-1:0] status_byte(stat_t s);
        logic [DW-1:0] b;
        b          = '0;
        b[ST_BUSY] = s.busy;
        b[ST_DONE] = s.done;
        b[ST_DEV]  = s.dev_err;
        b[ST_FAIL] = s.failed;
        b[ST_OWN]  = s.owned;
        b[ST_BYTE] = s.byte_done;
        return b;
    endfunction

    function automatic flag_clr_t clear_mask(logic [DW-1:0] d);
        flag_clr_t c;
        c.done      = d[ST_DONE];
        c.dev_err   = d[ST_DEV];
        c.failed    = d[ST_FAIL];
        c.owned     = d[ST_OWN];
        c.byte_done = d[ST_BYTE];
        return c;
    endfunction
endpackage

// File: rtl/smb_status_reg.sv
module smb_status_reg
    import smb_host_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      claim,       // status read that found the semaphore free
    input  flag_clr_t clr,         // write-one-to-clear mask (zero when no write)
    input  logic      start_pulse,
    input  logic      kill_pulse,
    input  logic      evt_done,
    input  logic      evt_dev_err,
    input  logic      evt_byte,
    output stat_t     st
);
    stat_t nxt;

    always_comb begin
        nxt = st;
        // Busy: set by start, ended by completion, device error or kill
        if (start_pulse)
            nxt.busy = 1'b1;
        else if (st.busy && (evt_done || evt_dev_err || kill_pulse))
            nxt.busy = 1'b0;
        // Sticky flags: hardware set wins over a same-cycle clear
        nxt.done      = (st.done      & ~clr.done)      | (st.busy & evt_done);
        nxt.dev_err   = (st.dev_err   & ~clr.dev_err)   | (st.busy & evt_dev_err);
        nxt.failed    = (st.failed    & ~clr.failed)    | (st.busy & kill_pulse);
        nxt.owned     = (st.owned     & ~clr.owned)     | claim;
        nxt.byte_done = (st.byte_done & ~clr.byte_done) | evt_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nxt;
    end

    AST_SEM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st.owned && !clr.owned) |=> st.owned); // R2
    AST_SEM_CLAIM: assert property (@(posedge clk) disable iff (rst)
        claim |=> st.owned); // R2
    AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> st.busy); // R5
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st.busy && evt_done && !start_pulse) |=> (!st.busy && st.done)); // R5
    AST_KILL_FAILS: assert property (@(posedge clk) disable iff (rst)
        (st.busy && kill_pulse && !start_pulse) |=> (!st.busy && st.failed)); // R6
    AST_BYTE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_byte |=> st.byte_done); // R12
endmodule

// File: rtl/smb_ctrl_reg.sv
module smb_ctrl_reg
    import smb_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,        // control register write this cycle
    input  logic               busy,
    input  logic               go_in,
    input  logic               kill_in,
    input  logic               ie_in,
    input  logic [PROTO_W-1:0] proto_in,
    output logic               ie,
    output logic [PROTO_W-1:0] proto,
    output logic               start_pulse,
    output logic               kill_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ie          <= 1'b0;
            proto       <= '0;
            start_pulse <= 1'b0;
            kill_pulse  <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            kill_pulse  <= 1'b0;
            if (wr) begin
                kill_pulse <= kill_in;           // kill always accepted
                if (!busy) begin
                    ie          <= ie_in;
                    proto       <= proto_in;
                    start_pulse <= go_in && !kill_in;
                end
            end
        end
    end

    AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R4
    AST_KILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        kill_pulse |=> !kill_pulse); // R6
    AST_CTRL_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(proto) && $stable(ie))); // R8
endmodule

// File: rtl/smb_data_regs.sv
module smb_data_regs
    import smb_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NDATA-1:0]  wr_hit,    // one-hot per register
    input  logic              busy,
    input  logic [DW-1:0]     wdata,
    input  logic              rx_valid,
    input  rx_tgt_e           rx_sel,
    input  logic [DW-1:0]     rx_byte,
    output logic [DW-1:0]     regs [NDATA]
);
    localparam int RX_BASE = OFS_D0 - OFS_CMD;  // first receive-loadable slot

    for (genvar i = 0; i < NDATA; i++) begin : g_reg
        logic rx_hit;
        if (i >= RX_BASE) begin : g_rx
            assign rx_hit = rx_valid && (rx_sel == rx_tgt_e'(i - RX_BASE));
        end else begin : g_norx
            assign rx_hit = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (rx_hit)
                regs[i] <= rx_byte;
            else if (wr_hit[i] && !busy)
                regs[i] <= wdata;
        end
    end

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(regs[0])); // R8
    AST_RX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_sel == RX_DATA0) |=> (regs[RX_BASE] == $past(rx_byte))); // R10
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               seq_start,
    output logic               seq_kill,
    output logic [PROTO_W-1:0] seq_proto,
    output logic [DW-1:0]      seq_cmd,
    output logic [DW-1:0]      seq_saddr,
    output logic [DW-1:0]      seq_data0,
    output logic [DW-1:0]      seq_data1,
    output logic [DW-1:0]      seq_blk,
    input  logic               seq_done,
    input  logic               seq_dev_err,
    input  logic               seq_byte_done,
    input  logic               seq_rx_valid,
    input  logic [1:0]         seq_rx_sel,
    input  logic [DW-1:0]      seq_rx_byte,
    output logic               irq
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    logic              rd_acc, wr_acc;
    logic              stat_rd, stat_wr, ctrl_wr;
    stat_t             st;
    flag_clr_t         clr;
    logic              ie;
    logic [DW-1:0]     dregs [NDATA];
    logic [NDATA-1:0]  data_hit;

    assign rd_acc  = bus_sel && !bus_we;
    assign wr_acc  = bus_sel &&  bus_we;
    assign stat_rd = rd_acc && (bus_addr == A_STAT);
    assign stat_wr = wr_acc && (bus_addr == A_STAT);
    assign ctrl_wr = wr_acc && (bus_addr == A_CTRL);
    assign clr     = stat_wr ? clear_mask(bus_wdata) : '0;

    for (genvar i = 0; i < NDATA; i++) begin : g_hit
        assign data_hit[i] = wr_acc && (bus_addr == ADDR_W'(OFS_CMD + i));
    end

    smb_status_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .claim       (stat_rd && !st.owned),
        .clr         (clr),
        .start_pulse (seq_start),
        .kill_pulse  (seq_kill),
        .evt_done    (seq_done),
        .evt_dev_err (seq_dev_err),
        .evt_byte    (seq_byte_done),
        .st          (st)
    );

    smb_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr          (ctrl_wr),
        .busy        (st.busy),
        .go_in       (bus_wdata[CT_GO]),
        .kill_in     (bus_wdata[CT_KILL]),
        .ie_in       (bus_wdata[CT_IE]),
        .proto_in    (bus_wdata[CT_PR_LO +: PROTO_W]),
        .ie          (ie),
        .proto       (seq_proto),
        .start_pulse (seq_start),
        .kill_pulse  (seq_kill)
    );

    smb_data_regs u_data (
        .clk      (clk),
        .rst      (rst),
        .wr_hit   (data_hit),
        .busy     (st.busy),
        .wdata    (bus_wdata),
        .rx_valid (seq_rx_valid),
        .rx_sel   (rx_tgt_e'(seq_rx_sel)),
        .rx_byte  (seq_rx_byte),
        .regs     (dregs)
    );

    assign seq_cmd   = dregs[OFS_CMD  - OFS_CMD];
    assign seq_saddr = dregs[OFS_SADR - OFS_CMD];
    assign seq_data0 = dregs[OFS_D0   - OFS_CMD];
    assign seq_data1 = dregs[OFS_D1   - OFS_CMD];
    assign seq_blk   = dregs[OFS_BLK  - OFS_CMD];

    assign irq = ie && (st.done || st.dev_err || st.failed);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STAT)
            bus_rdata = status_byte(st);
        else if (bus_addr == A_CTRL) begin
            bus_rdata[CT_IE]                 = ie;
            bus_rdata[CT_PR_LO +: PROTO_W]   = seq_proto;
        end else if (bus_addr >= ADDR_W'(OFS_CMD))
            bus_rdata = dregs[int'(bus_addr) - OFS_CMD];
    end

    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (ie && st.done) |-> irq); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st.done || st.dev_err || st.failed)); // R7
    AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        st.busy |-> !seq_start); // R8
endmodule

// File: tb/tb_smb_host_regs.sv
`timescale 1ns/1ps
module tb_smb_host_regs;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_we;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       seq_start, seq_kill;
    logic [2:0] seq_proto;
    logic [7:0] seq_cmd, seq_saddr, seq_data0, seq_data1, seq_blk;
    logic       seq_done, seq_dev_err, seq_byte_done, seq_rx_valid;
    logic [1:0] seq_rx_sel;
    logic [7:0] seq_rx_byte;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    smb_host_regs dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_start(seq_start), .seq_kill(seq_kill), .seq_proto(seq_proto),
        .seq_cmd(seq_cmd), .seq_saddr(seq_saddr), .seq_data0(seq_data0),
        .seq_data1(seq_data1), .seq_blk(seq_blk),
        .seq_done(seq_done), .seq_dev_err(seq_dev_err),
        .seq_byte_done(seq_byte_done), .seq_rx_valid(seq_rx_valid),
        .seq_rx_sel(seq_rx_sel), .seq_rx_byte(seq_rx_byte), .irq(irq)
    );

    // {offset, write data, expected readback}
    localparam logic [23:0] VEC [10] = '{
        {8'd3, 8'hA5, 8'hA5},
        {8'd4, 8'h6D, 8'h6D},
        {8'd5, 8'h01, 8'h01},
        {8'd6, 8'hFE, 8'hFE},
        {8'd7, 8'h3C, 8'h3C},
        {8'd1, 8'hFF, 8'h00},
        {8'd3, 8'h00, 8'h00},
        {8'd2, 8'h05, 8'h05},
        {8'd2, 8'h1D, 8'h1D},
        {8'd2, 8'h80, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        seq_done = 0; seq_dev_err = 0; seq_byte_done = 0;
        seq_rx_valid = 0; seq_rx_sel = 0; seq_rx_byte = 0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 proto", {5'd0, seq_proto}, 8'h00);
        check("R1 cmd", seq_cmd, 8'h00);
        expect_reg("R1 status after reset", 3'd0, 8'h00);   // claims semaphore
        // R2 semaphore
        expect_reg("R2 semaphore taken", 3'd0, 8'h40);
        bus_write(3'd0, 8'hBF);
        expect_reg("R3 0xBF keeps semaphore", 3'd0, 8'h40);
        bus_write(3'd0, 8'h40);
        expect_reg("R2 released reads free", 3'd0, 8'h00);
        expect_reg("R2 reclaimed", 3'd0, 8'h40);

        // R11 register map walk
        for (int i = 0; i < 10; i++) begin
            bus_write(VEC[i][18:16], VEC[i][15:8]);
            expect_reg("R11 readback", VEC[i][18:16], VEC[i][7:0]);
        end
        bus_write(3'd2, 8'h00);

        // R4/R5 start and completion
        bus_write(3'd3, 8'h12);
        bus_write(3'd4, 8'hA0);
        bus_write(3'd2, 8'h48);
        check("R4 start pulse", {7'd0, seq_start}, 8'h01);
        check("R4 protocol", {5'd0, seq_proto}, 8'h02);
        check("R11 cmd out", seq_cmd, 8'h12);
        check("R11 addr out", seq_saddr, 8'hA0);
        idle(1);
        check("R4 start single cycle", {7'd0, seq_start}, 8'h00);
        expect_reg("R5 busy set", 3'd0, 8'h41);
        expect_reg("R4 start reads 0", 3'd2, 8'h08);

        // R8 writes ignored while busy
        bus_write(3'd3, 8'h99);
        expect_reg("R8 cmd held", 3'd3, 8'h12);
        bus_write(3'd2, 8'h45);
        expect_reg("R8 ctrl held", 3'd2, 8'h08);
        check("R8 no start while busy", {7'd0, seq_start}, 8'h00);
        bus_write(3'd6, 8'h33);
        expect_reg("R8 data1 held", 3'd6, 8'hFE);

        // R10 receive loads
        seq_rx_valid = 1; seq_rx_sel = 2'd0; seq_rx_byte = 8'h77;
        idle(1);
        seq_rx_sel = 2'd2; seq_rx_byte = 8'hC9;
        idle(1);
        seq_rx_valid = 0;
        expect_reg("R10 data0 loaded", 3'd5, 8'h77);
        check("R10 block loaded", seq_blk, 8'hC9);

        // R9 byte done
        seq_byte_done = 1; idle(1); seq_byte_done = 0;
        expect_reg("R9 byte done", 3'd0, 8'hC1);

        // R5 completion
        seq_done = 1; idle(1); seq_done = 0;
        expect_reg("R5 done ends busy", 3'd0, 8'hC2);
        check("R7 irq masked", {7'd0, irq}, 8'h00);
        bus_write(3'd2, 8'h01);
        check("R7 irq enabled", {7'd0, irq}, 8'h01);
        bus_write(3'd0, 8'h02);
        check("R7 irq after clear", {7'd0, irq}, 8'h00);
        expect_reg("R3 single clear", 3'd0, 8'hC0);
        bus_write(3'd0, 8'hFF);
        expect_reg("R3 0xFF clears all", 3'd0, 8'h00);     // claims again

        // R5 device error ends busy
        bus_write(3'd2, 8'h45);
        idle(1);
        seq_dev_err = 1; idle(1); seq_dev_err = 0;
        expect_reg("R5 device error", 3'd0, 8'h44);
        check("R7 irq on device error", {7'd0, irq}, 8'h01);
        bus_write(3'd0, 8'hFF);

        // R6 kill while busy
        bus_write(3'd2, 8'h45);
        idle(1);
        expect_reg("R5 busy again", 3'd0, 8'h01);
        bus_write(3'd2, 8'h02);
        check("R6 kill pulse", {7'd0, seq_kill}, 8'h01);
        idle(1);
        check("R6 kill single cycle", {7'd0, seq_kill}, 8'h00);
        expect_reg("R6 kill fails busy", 3'd0, 8'h50);
        check("R8 enable kept over kill write", {7'd0, irq}, 8'h01);

        // R6 kill while idle
        bus_write(3'd0, 8'hFF);
        bus_write(3'd2, 8'h02);
        check("R6 idle kill pulse", {7'd0, seq_kill}, 8'h00 | 8'h01);
        idle(1);
        expect_reg("R6 idle kill no flag", 3'd0, 8'h00);

        // R12 set wins over clear
        seq_byte_done = 1;
        bus_write(3'd0, 8'h80);
        seq_byte_done = 0;
        expect_reg("R12 set wins", 3'd0, 8'hC0);
        bus_write(3'd0, 8'h80);
        expect_reg("R3 byte flag clear", 3'd0, 8'h40);

        // R1 reset while busy
        bus_write(3'd2, 8'h44);
        idle(1);
        rst = 1'b1; idle(2); rst = 1'b0;
        idle(1);
        check("R1 proto after reset", {5'd0, seq_proto}, 8'h00);
        expect_reg("R1 busy dropped", 3'd0, 8'h00);
        expect_reg("R1 cmd cleared", 3'd3, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule